// File: doc/BRIEF.md
# Edge-Select Interrupting GPIO Port

This block is a sixteen-pin general-purpose I/O port controlled through a simple 16-bit register bus. Software sets each pin as input or output, writes output levels, and reads the input levels through a per-pin visibility gate. Input pins pass through a two-flop synchronizer. A per-pin polarity bit then selects whether a rising or a falling transition is reported.

Reported transitions collect in a sticky status register that software clears by writing ones. A single shared interrupt line follows the OR of all status bits, one cycle late. Output levels and output enables are driven straight from the output-value and direction registers, so a direction change re-drives the affected pins at once.

Top module: `gpio_edge_port`

## Requirements
- R1: Byte offsets: 0x00 input view (read-only, writes ignored), 0x04 output value, 0x08 direction, 0x0C edge polarity, 0x10 interrupt mask, 0x14 status, 0x18 pin visibility. Reads of any other offset return zero, and writes to them change nothing.
- R2: A direction bit of 1 makes the pin an input. `pin_oe` is the inverse of direction, and `pin_out` is the output value ANDed with the inverted direction. Both follow a direction or output-value write in the cycle after it.
- R3: An edge-polarity bit of 1 reports a rising transition on that pin, and a bit of 0 reports a falling transition. The opposite transition is not reported.
- R4: A reported transition sets its status bit only when the pin's direction bit is 1 and its mask bit is 0.
- R5: Writing to the status offset clears each status bit written as 1 and leaves the others unchanged.
- R6: `irq` is 1 exactly one cycle after any status bit is 1. It stays 1 until all status bits are clear, and falls one cycle after the last bit clears.
- R7: When a status bit is set and cleared in the same cycle, it ends up set.
- R8: A read at offset 0x00 returns the synchronized pin levels ANDed with the pin-visibility register. A pin change is visible two clock edges after it is sampled, and a status bit sets on the third edge.
- R9: After reset, output value, direction, edge polarity, mask and pin visibility read 0xFFFF, and the input view and status read zero.
- R10: Only accesses with `bus_size` = 1 (16-bit) act. Writes of any other size are ignored, and reads of any other size return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_size | input | 2 | Access size code; 1 = 16-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read strobe |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output levels |
| pin_oe | output | 16 | Output enables |
| irq | output | 1 | Shared interrupt |

## Verification
The main sweep moves each pin in turn through both a rising and a falling transition, under all eight combinations of that pin's direction, mask and polarity bits. Only one of the eight combinations may set status for a given transition, so this separates polarity errors, direction gating and mask sense from each other. Two pins firing together and then being cleared one at a time show that the interrupt holds until the last bit goes, with its one-cycle lag. A clear write timed onto the cycle of a set shows the priority between the two. Separate patterns on the input view, the output drive, odd-size and unmapped accesses, and the reset values cover the register file.

// File: rtl/gpio_edge_pkg.sv
// Package: register offsets and bus codes shared by the GPIO port modules.
package gpio_edge_pkg;
    localparam int          REG_AW    = 8;
    localparam logic [7:0]  OFS_DIN   = 8'h00;
    localparam logic [7:0]  OFS_DOUT  = 8'h04;
    localparam logic [7:0]  OFS_DIR   = 8'h08;
    localparam logic [7:0]  OFS_EDGE  = 8'h0C;
    localparam logic [7:0]  OFS_MASK  = 8'h10;
    localparam logic [7:0]  OFS_STAT  = 8'h14;
    localparam logic [7:0]  OFS_PEN   = 8'h18;
    localparam logic [1:0]  SIZE_HALF = 2'd1;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes: SYNC_STAGES >= 1; reset value of every stage is zero.
module gpio_in_sync #(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_sync
);
    logic [SYNC_STAGES-1:0][NPINS-1:0] stage_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q[0] <= pin_in;
            end
        end else begin : g_chain
            // Shift chain: stage 0 captures the pins, each later stage follows.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    assign pin_sync = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/gpio_edge_status.sv
// Module: gpio_edge_status
// Detects the chosen transition per pin, keeps sticky status bits and
// drives the shared interrupt one cycle after status.
// Assumes: din is already synchronous; clr_vec is a one-cycle pulse vector.
module gpio_edge_status #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] edge_sel,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] status,
    output logic             irq
);
    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] status_q;
    logic             irq_q;
    logic [NPINS-1:0] rise, fall, hit, set_vec;

    // Previous synchronized level, the reference for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    // Qualify transitions by polarity, direction and mask.
    always_comb begin
        rise    = din & ~prev_q;
        fall    = ~din & prev_q;
        hit     = (rise & edge_sel) | (fall & ~edge_sel);
        set_vec = hit & dir & ~mask;
    end

    // Sticky status: a set in the same cycle overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // Interrupt follows the OR of status with one register of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |status_q;
    end

    assign status = status_q;
    assign irq    = irq_q;

    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    assert_irq_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == $past(|status_q));
endmodule

// File: rtl/gpio_edge_regs.sv
// Module: gpio_edge_regs
// Register file and read mux for the port; emits the status-clear vector.
// Assumes: one access per bus_sel cycle; read data is combinational.
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  din_sync,
    input  logic [NPINS-1:0]  status,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  edge_sel,
    output logic [NPINS-1:0]  mask,
    output logic [NPINS-1:0]  clr_vec
);
    logic [NPINS-1:0] dout_q, dir_q, edge_q, mask_q, pen_q;
    logic             acc_ok, wr_ok, rd_ok;

    // Decode a legal-size access.
    always_comb begin
        acc_ok = bus_sel && (bus_size == SIZE_HALF);
        wr_ok  = acc_ok && bus_write;
        rd_ok  = acc_ok && !bus_write;
    end

    // Writable configuration registers; all ones out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '1;
            dir_q  <= '1;
            edge_q <= '1;
            mask_q <= '1;
            pen_q  <= '1;
        end else if (wr_ok) begin
            case (bus_addr)
                OFS_DOUT: dout_q <= bus_wdata;
                OFS_DIR:  dir_q  <= bus_wdata;
                OFS_EDGE: edge_q <= bus_wdata;
                OFS_MASK: mask_q <= bus_wdata;
                OFS_PEN:  pen_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Status clear pulse from a legal write to the status offset.
    always_comb begin
        clr_vec = (wr_ok && bus_addr == OFS_STAT) ? bus_wdata : '0;
    end

    // Read mux; unmapped offsets and illegal sizes return zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_ok) begin
            case (bus_addr)
                OFS_DIN:  bus_rdata = din_sync & pen_q;
                OFS_DOUT: bus_rdata = dout_q;
                OFS_DIR:  bus_rdata = dir_q;
                OFS_EDGE: bus_rdata = edge_q;
                OFS_MASK: bus_rdata = mask_q;
                OFS_STAT: bus_rdata = status;
                OFS_PEN:  bus_rdata = pen_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign dout     = dout_q;
    assign dir      = dir_q;
    assign edge_sel = edge_q;
    assign mask     = mask_q;

    assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_write && bus_size != SIZE_HALF) |=>
        ($stable(dout_q) && $stable(dir_q) && $stable(edge_q) &&
         $stable(mask_q) && $stable(pen_q)));
endmodule

// File: rtl/gpio_edge_port.sv
// Module: gpio_edge_port (top)
// Sixteen-pin GPIO port with per-pin edge polarity, masked sticky status
// and one shared interrupt.
// Assumes: pin_in is asynchronous; the bus is synchronous to clk.
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    logic [NPINS-1:0] din_sync, dout, dir, edge_sel, mask, clr_vec, status;

    gpio_in_sync #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(din_sync)
    );

    gpio_edge_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .din_sync(din_sync), .status(status),
        .dout(dout), .dir(dir), .edge_sel(edge_sel), .mask(mask),
        .clr_vec(clr_vec)
    );

    gpio_edge_status #(.NPINS(NPINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .din(din_sync), .dir(dir),
        .edge_sel(edge_sel), .mask(mask), .clr_vec(clr_vec),
        .status(status), .irq(irq)
    );

    // Output drive: enabled where direction is 0; re-driven on any change.
    always_comb begin
        pin_oe  = ~dir;
        pin_out = dout & ~dir;
    end

    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((status & ~$past(status)) & ~($past(dir) & ~$past(mask))) == '0));
endmodule

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd1;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic [15:0] pin_in = '0, pin_out, pin_oe;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    logic [15:0] rd;

    gpio_edge_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz = 2'd1);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_write = 1'b0; bus_size = 2'd1;
    endtask

    task automatic rdb(input logic [7:0] a, output logic [15:0] d, input logic [1:0] sz = 2'd1);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        #2 d = bus_rdata;
        bus_sel = 1'b0; bus_size = 2'd1;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9: reset values
        rdb(8'h04, rd); chk("R9 dout", rd, 16'hFFFF);
        rdb(8'h08, rd); chk("R9 dir", rd, 16'hFFFF);
        rdb(8'h0C, rd); chk("R9 edge", rd, 16'hFFFF);
        rdb(8'h10, rd); chk("R9 mask", rd, 16'hFFFF);
        rdb(8'h18, rd); chk("R9 pen", rd, 16'hFFFF);
        rdb(8'h14, rd); chk("R9 status", rd, 16'h0000);
        rdb(8'h00, rd); chk("R9 din", rd, 16'h0000);
        chk("R9 irq", {15'd0, irq}, 16'h0);
        chk("R9 pin_oe", pin_oe, 16'h0000);

        // R8: input view timing and visibility gate
        @(negedge clk) pin_in = 16'hA5C3;
        @(posedge clk);
        rdb(8'h00, rd); chk("R8 one edge", rd, 16'h0000);
        rdb(8'h00, rd); chk("R8 two edges", rd, 16'hA5C3);
        wr(8'h18, 16'h0FF0);
        rdb(8'h00, rd); chk("R8 gated", rd, 16'h05C0);

        // R1: input view read-only, unmapped offset
        wr(8'h00, 16'h1234);
        rdb(8'h00, rd); chk("R1 din ro", rd, 16'h05C0);
        wr(8'h04, 16'h3C5A);
        rdb(8'h04, rd); chk("R1 dout rw", rd, 16'h3C5A);
        wr(8'h1C, 16'h0000);
        rdb(8'h1C, rd); chk("R1 unmapped read", rd, 16'h0000);
        rdb(8'h04, rd); chk("R1 unmapped write", rd, 16'h3C5A);
        wr(8'h18, 16'hFFFF);

        // R10: odd sizes
        wr(8'h04, 16'h0000, 2'd0);
        rdb(8'h04, rd); chk("R10 byte write", rd, 16'h3C5A);
        wr(8'h08, 16'h0000, 2'd2);
        rdb(8'h08, rd); chk("R10 word write", rd, 16'hFFFF);
        rdb(8'h04, rd, 2'd2); chk("R10 word read", rd, 16'h0000);

        // R2: output drive and re-drive on direction change
        wr(8'h04, 16'h00F0);
        wr(8'h08, 16'hFF0F);
        chk("R2 out", pin_out, 16'h00F0);
        chk("R2 oe", pin_oe, 16'h00F0);
        wr(8'h08, 16'hFFFF);
        chk("R2 all input", pin_out, 16'h0000);
        wr(8'h08, 16'h0000);
        chk("R2 all output", pin_out, 16'h00F0);
        chk("R2 oe all", pin_oe, 16'hFFFF);

        // R3 R4 R6: sweep every pin, both transitions, all bit combinations
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int r = 0; r < 2; r++) begin
                    logic db, mb, eb;
                    logic [15:0] exp;
                    db = m[0]; mb = m[1]; eb = m[2];
                    wr(8'h08, {16{db}});
                    wr(8'h10, {16{mb}});
                    wr(8'h0C, {16{eb}});
                    @(negedge clk) pin_in = (r == 1) ? 16'h0 : (16'h1 << p);
                    repeat (3) @(posedge clk);
                    wr(8'h14, 16'hFFFF);
                    repeat (2) @(posedge clk);
                    @(negedge clk) pin_in = (r == 1) ? (16'h1 << p) : 16'h0;
                    repeat (3) @(posedge clk);
                    exp = (db && !mb && (eb == (r == 1))) ? (16'h1 << p) : 16'h0;
                    rdb(8'h14, rd); chk("R3 R4 status", rd, exp);
                    chk("R6 irq lag", {15'd0, irq}, 16'h0);
                    @(posedge clk); #1;
                    chk("R6 irq", {15'd0, irq}, {15'd0, exp != 0});
                end
            end
        end

        // R5 R6: two bits, clear one at a time
        wr(8'h08, 16'hFFFF); wr(8'h10, 16'h0000); wr(8'h0C, 16'hFFFF);
        @(negedge clk) pin_in = 16'h0;
        repeat (3) @(posedge clk);
        wr(8'h14, 16'hFFFF);
        repeat (2) @(posedge clk);
        @(negedge clk) pin_in = 16'h0006;
        repeat (4) @(posedge clk);
        rdb(8'h14, rd); chk("R5 both set", rd, 16'h0006);
        wr(8'h14, 16'h0002);
        rdb(8'h14, rd); chk("R5 partial clear", rd, 16'h0004);
        @(posedge clk); #1;
        chk("R6 irq held", {15'd0, irq}, 16'h1);
        wr(8'h14, 16'h0004);
        chk("R6 irq drop lag", {15'd0, irq}, 16'h1);
        @(posedge clk); #1;
        chk("R6 irq dropped", {15'd0, irq}, 16'h0);

        // R7: clear lands on the cycle the set arrives
        @(negedge clk) pin_in = 16'h000E;
        repeat (2) @(posedge clk);
        wr(8'h14, 16'h0008);
        rdb(8'h14, rd); chk("R7 set wins", rd, 16'h0008);

        finish_run();
    end
endmodule